// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end of a byte-wide, electrically erasable flash memory. A parallel bus with active-low chip enable, output enable and write enable, plus address and data lines, reaches a small behavioural byte array. Bus write cycles load a command register, and that register steers a state machine through identifier read, program, program verify, erase and erase verify. A write cycle also captures the address and data that a following program or verify step needs.

Contents can only change while the high-voltage-present input is high. With that input low, the part is a plain read-only memory: array reads, standby, output disable and identifier reads through a dedicated identifier pin still work, and every command write is dropped. A built-in stop timer ends each program or erase pulse after a fixed number of clock cycles. The part then sits idle until a verify or a reset command arrives. A verify command written during a pulse ends that pulse early. If high voltage is lost mid-pulse, the operation is cancelled and the array is left as it was.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the mode is array read, `busy` is 0, every byte reads 0xFF, and `dout_en` is 0 while the bus is idle.
- R2: A read cycle (`ce_n`=0, `oe_n`=0, `we_n`=1) drives `dout_en`=1. In array-read mode it returns the byte at `addr`. When no read cycle is active, `dout_en`=0 and `dout`=0x00.
- R3: Identifier codes are 0x5A when `addr[0]`=0 and 0xB3 when `addr[0]`=1. They are returned during any read with `id_pin`=1, whether `hv_ok` is high or low, and also after command 0x90 is written while `hv_ok`=1.
- R4: While `hv_ok`=0, every command write is ignored. `busy` stays 0, the array does not change, and reads return array data.
- R5: Command 0x40 followed by a write of address A and data D starts a program pulse. When the pulse ends, byte A holds its old value AND D.
- R6: Command 0x20 starts an erase pulse. When the pulse ends, every byte is 0xFF.
- R7: `busy` rises on the clock edge that samples the starting write. It falls exactly PULSE_CYC edges later unless the pulse ends early. After that the block ignores every write except 0xA0, 0xC0 and 0xFF.
- R8: Writing 0xC0 during a program pulse, or 0xA0 during an erase pulse, ends the pulse on that edge and commits the operation.
- R9: Writing 0xA0 or 0xC0 latches the address of that write cycle. Later reads return the byte stored at that latched address, whatever the bus address.
- R10: Writing 0xFF twice in a row returns the block to array-read mode. After a single 0xFF, reads return array data and the next command is decoded normally.
- R11: If `hv_ok` falls during a pulse, `busy` is 0 after the next edge, the addressed bytes keep their old values, and the mode is array read.
- R12: During a pulse, any write other than the matching verify command is ignored, and the stop timer keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; one write per sampled cycle |
| id_pin | input | 1 | Forces identifier codes onto read cycles |
| hv_ok | input | 1 | High voltage present; gates the command register |
| addr | input | AW | Byte address |
| din | input | 8 | Write data / command byte |
| dout | output | 8 | Read data, 0 outside read cycles |
| dout_en | output | 1 | High during a read cycle |
| busy | output | 1 | A program or erase pulse is running |

## Verification
The bench counts the exact edge on which the stop timer drops `busy`. A counter that is off by one would show up as `busy` one cycle too long or too short. It also checks that a second program to the same byte ANDs with the old value; a design that overwrites would leave the raw data there. A verify written mid-pulse must both end the pulse and commit the data, and a loss of high voltage mid-pulse must leave the byte untouched. Writes sent while the part is idle after the timer has expired, or while high voltage is absent, are shown to have had no effect by reading back the bytes they would have changed.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    M_READ,
    M_ID,
    M_RST1,
    M_PGM_SETUP,
    M_PGM_PULSE,
    M_ERS_PULSE,
    M_INACTIVE,
    M_PGM_VFY,
    M_ERS_VFY
  } mode_e;

  localparam logic [7:0] OP_READ    = 8'h00;
  localparam logic [7:0] OP_ID      = 8'h90;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_ERS_VFY = 8'hA0;
  localparam logic [7:0] OP_PROG    = 8'h40;
  localparam logic [7:0] OP_PRG_VFY = 8'hC0;
  localparam logic [7:0] OP_RESET   = 8'hFF;

  // Programming can only clear bits.
  function automatic logic [7:0] prog_merge(input logic [7:0] old_b, input logic [7:0] data_b);
    return old_b & data_b;
  endfunction

  function automatic logic [7:0] id_code(input logic sel, input logic [7:0] mfr, input logic [7:0] dev);
    return sel ? dev : mfr;
  endfunction

  function automatic logic is_pulse(input mode_e m);
    return (m == M_PGM_PULSE) || (m == M_ERS_PULSE);
  endfunction

  function automatic logic is_verify_op(input logic [7:0] op);
    return (op == OP_ERS_VFY) || (op == OP_PRG_VFY);
  endfunction

  // Next mode for a command written while no pulse or idle wait is pending.
  function automatic mode_e decode_cmd(input mode_e cur, input logic [7:0] op);
    case (op)
      OP_READ:    return M_READ;
      OP_ID:      return M_ID;
      OP_PROG:    return M_PGM_SETUP;
      OP_ERASE:   return M_ERS_PULSE;
      OP_ERS_VFY: return M_ERS_VFY;
      OP_PRG_VFY: return M_PGM_VFY;
      OP_RESET:   return (cur == M_RST1) ? M_READ : M_RST1;
      default:    return cur;
    endcase
  endfunction

endpackage

// File: rtl/flash_stop_timer.sv
module flash_stop_timer #(
  parameter int PULSE_CYC = 20,
  parameter int TW        = $clog2(PULSE_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [TW-1:0] cnt,
  output logic          done
);

  localparam logic [TW-1:0] LAST = TW'(PULSE_CYC - 1);

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (!done)     cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array
  import flash_cmd_pkg::*;
#(
  parameter int AW    = 4,
  parameter int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pgm_we,
  input  logic [AW-1:0] pgm_addr,
  input  logic [7:0]    pgm_data,
  input  logic          ers_we,
  input  logic [AW-1:0] rd_addr_a,
  output logic [7:0]    rd_data_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [7:0]    rd_data_b
);

  logic [DEPTH-1:0][7:0] cells;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n || ers_we)
        cells[g] <= 8'hFF;
      else if (pgm_we && (pgm_addr == AW'(g)))
        cells[g] <= prog_merge(cells[g], pgm_data);
    end
  end

  assign rd_data_a = cells[rd_addr_a];
  assign rd_data_b = cells[rd_addr_b];

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hv_ok,
  input  logic          wr_evt,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  input  logic          pulse_done,
  output mode_e         mode,
  output logic          busy,
  output logic [AW-1:0] pgm_addr,
  output logic [7:0]    pgm_data,
  output logic [AW-1:0] vfy_addr,
  output logic          pgm_commit,
  output logic          ers_commit
);

  logic vfy_hit_pgm;
  logic vfy_hit_ers;

  assign vfy_hit_pgm = wr_evt && (mode == M_PGM_PULSE) && (din == OP_PRG_VFY);
  assign vfy_hit_ers = wr_evt && (mode == M_ERS_PULSE) && (din == OP_ERS_VFY);
  assign busy        = is_pulse(mode);
  assign pgm_commit  = hv_ok && (mode == M_PGM_PULSE) && (pulse_done || vfy_hit_pgm);
  assign ers_commit  = hv_ok && (mode == M_ERS_PULSE) && (pulse_done || vfy_hit_ers);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= M_READ;
      pgm_addr <= '0;
      pgm_data <= '0;
      vfy_addr <= '0;
    end else if (!hv_ok) begin
      mode <= M_READ;
    end else begin
      case (mode)
        M_PGM_SETUP: begin
          if (wr_evt) begin
            pgm_addr <= addr;
            pgm_data <= din;
            mode     <= M_PGM_PULSE;
          end
        end
        M_PGM_PULSE: begin
          if (vfy_hit_pgm) begin
            mode     <= M_PGM_VFY;
            vfy_addr <= addr;
          end else if (pulse_done) begin
            mode <= M_INACTIVE;
          end
        end
        M_ERS_PULSE: begin
          if (vfy_hit_ers) begin
            mode     <= M_ERS_VFY;
            vfy_addr <= addr;
          end else if (pulse_done) begin
            mode <= M_INACTIVE;
          end
        end
        M_INACTIVE: begin
          if (wr_evt && (is_verify_op(din) || din == OP_RESET)) begin
            mode <= decode_cmd(mode, din);
            if (is_verify_op(din)) vfy_addr <= addr;
          end
        end
        default: begin
          if (wr_evt) begin
            mode <= decode_cmd(mode, din);
            if (is_verify_op(din)) vfy_addr <= addr;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int          AW        = 4,
  parameter int          PULSE_CYC = 20,
  parameter logic [7:0]  MFR_CODE  = 8'h5A,
  parameter logic [7:0]  DEV_CODE  = 8'hB3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          id_pin,
  input  logic          hv_ok,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic          dout_en,
  output logic          busy
);

  localparam int TW    = $clog2(PULSE_CYC + 1);
  localparam int DEPTH = 1 << AW;

  mode_e          mode;
  logic           wr_evt;
  logic           rd_evt;
  logic           pulse_done;
  logic [TW-1:0]  tmr_cnt;
  logic [AW-1:0]  pgm_addr;
  logic [7:0]     pgm_data;
  logic [AW-1:0]  vfy_addr;
  logic           pgm_commit;
  logic           ers_commit;
  logic [7:0]     arr_bus;
  logic [7:0]     arr_vfy;

  assign wr_evt = !ce_n && !we_n && oe_n;
  assign rd_evt = !ce_n && !oe_n && we_n;

  flash_cmd_fsm #(.AW(AW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .hv_ok      (hv_ok),
    .wr_evt     (wr_evt),
    .addr       (addr),
    .din        (din),
    .pulse_done (pulse_done),
    .mode       (mode),
    .busy       (busy),
    .pgm_addr   (pgm_addr),
    .pgm_data   (pgm_data),
    .vfy_addr   (vfy_addr),
    .pgm_commit (pgm_commit),
    .ers_commit (ers_commit)
  );

  flash_stop_timer #(.PULSE_CYC(PULSE_CYC), .TW(TW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .cnt   (tmr_cnt),
    .done  (pulse_done)
  );

  flash_cell_array #(.AW(AW), .DEPTH(DEPTH)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .pgm_we    (pgm_commit),
    .pgm_addr  (pgm_addr),
    .pgm_data  (pgm_data),
    .ers_we    (ers_commit),
    .rd_addr_a (addr),
    .rd_data_a (arr_bus),
    .rd_addr_b (vfy_addr),
    .rd_data_b (arr_vfy)
  );

  always_comb begin
    dout_en = rd_evt;
    if (!rd_evt)
      dout = 8'h00;
    else if (id_pin || mode == M_ID)
      dout = id_code(addr[0], MFR_CODE, DEV_CODE);
    else if (mode == M_PGM_VFY || mode == M_ERS_VFY)
      dout = arr_vfy;
    else
      dout = arr_bus;
  end

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int PULSE_CYC = 20,
  parameter int TW        = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hv_ok,
  input logic          busy,
  input logic          wr_evt,
  input logic          pulse_done,
  input logic          pgm_commit,
  input logic          ers_commit,
  input logic [7:0]    dout,
  input logic          dout_en,
  input logic [TW-1:0] tmr_cnt
);

  AST_NO_BUSY_WITHOUT_HV: assert property (@(posedge clk) disable iff (!rst_n)
    !hv_ok |=> !busy); // R11

  AST_COMMIT_NEEDS_HV: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_commit || ers_commit) |-> hv_ok); // R4

  AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(pgm_commit && ers_commit)); // R5

  AST_TIMER_ENDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_done |=> !busy); // R7

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tmr_cnt < TW'(PULSE_CYC))); // R7

  AST_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_evt)); // R5

  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == 8'h00)); // R2

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.PULSE_CYC(PULSE_CYC), .TW(TW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hv_ok      (hv_ok),
  .busy       (busy),
  .wr_evt     (wr_evt),
  .pulse_done (pulse_done),
  .pgm_commit (pgm_commit),
  .ers_commit (ers_commit),
  .dout       (dout),
  .dout_en    (dout_en),
  .tmr_cnt    (u_timer.cnt)
);

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;

  localparam int AW = 4;
  localparam int P  = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic          id_pin = 1'b0, hv_ok = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic [7:0]    dout;
  logic          dout_en;
  logic          busy;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] mexp [16];

  always #10 clk = ~clk;

  flash_cmd_ctrl #(.AW(AW), .PULSE_CYC(P)) i_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .id_pin(id_pin), .hv_ok(hv_ok), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en), .busy(busy)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; addr = a;
    #2;
    chk(req, {7'd0, dout_en}, 8'd1);
    chk(req, dout, exp);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 16; i++) mexp[i] = 8'hFF;
    chk("R1 busy", {7'd0, busy}, 8'd0);
    chk("R1 dout_en idle", {7'd0, dout_en}, 8'd0);
    chk("R2 dout idle", dout, 8'h00);
    rd_chk("R1 erased at 3", 3, 8'hFF);
    rd_chk("R2 array read 12", 12, 8'hFF);
  endtask

  task automatic t_ident;
    wr(0, 8'h90);
    rd_chk("R3 mfr by command", 0, 8'h5A);
    rd_chk("R3 dev by command", 1, 8'hB3);
    wr(0, 8'hFF); wr(0, 8'hFF);
    rd_chk("R10 array after double reset", 1, 8'hFF);
    hv_ok = 1'b0;
    id_pin = 1'b1;
    rd_chk("R3 mfr by pin, no hv", 2, 8'h5A);
    rd_chk("R3 dev by pin, no hv", 3, 8'hB3);
    id_pin = 1'b0;
    hv_ok = 1'b1;
  endtask

  task automatic t_program;
    wr(0, 8'h40);
    wr(5, 8'hA5);
    chk("R7 busy rises", {7'd0, busy}, 8'd1);
    cycles(P - 1);
    chk("R7 busy still high at P-1", {7'd0, busy}, 8'd1);
    cycles(1);
    chk("R7 busy falls at P", {7'd0, busy}, 8'd0);
    mexp[5] = 8'hA5;
    rd_chk("R5 programmed byte", 5, mexp[5]);
    wr(5, 8'hC0);
    rd_chk("R9 program verify", 0, mexp[5]);
    wr(0, 8'h40);
    wr(5, 8'h3C);
    cycles(P);
    mexp[5] = 8'hA5 & 8'h3C;
    rd_chk("R5 AND with old value", 5, mexp[5]);
    // idle after timer: program sequence must be dropped
    wr(0, 8'h40);
    wr(6, 8'h00);
    cycles(P + 1);
    chk("R7 no pulse while inactive", {7'd0, busy}, 8'd0);
    rd_chk("R7 byte 6 untouched", 6, mexp[6]);
    wr(5, 8'hC0);
    rd_chk("R9 verify addr latched", 0, mexp[5]);
    wr(0, 8'hFF); wr(0, 8'hFF);
  endtask

  task automatic t_early_verify;
    wr(0, 8'h40);
    wr(9, 8'h0F);
    cycles(2);
    wr(0, 8'h20);
    chk("R12 other cmd ignored in pulse", {7'd0, busy}, 8'd1);
    rd_chk("R12 no erase from stray cmd", 5, mexp[5]);
    wr(9, 8'hC0);
    chk("R8 program ends early", {7'd0, busy}, 8'd0);
    mexp[9] = 8'h0F;
    rd_chk("R8 commit on verify", 2, mexp[9]);
    wr(0, 8'hFF); wr(0, 8'hFF);
  endtask

  task automatic t_erase;
    wr(0, 8'h20);
    chk("R6 erase busy", {7'd0, busy}, 8'd1);
    cycles(P);
    chk("R7 erase busy falls", {7'd0, busy}, 8'd0);
    for (int i = 0; i < 16; i++) mexp[i] = 8'hFF;
    rd_chk("R6 byte 5 erased", 5, 8'hFF);
    rd_chk("R6 byte 9 erased", 9, 8'hFF);
    wr(9, 8'hA0);
    rd_chk("R9 erase verify", 4, 8'hFF);
    wr(0, 8'h40);
    wr(1, 8'h11);
    cycles(P);
    wr(1, 8'hC0);
    rd_chk("R5 byte 1 programmed", 7, 8'h11);
    wr(0, 8'h20);
    cycles(2);
    wr(1, 8'hA0);
    chk("R8 erase ends early", {7'd0, busy}, 8'd0);
    rd_chk("R8 erase committed", 3, 8'hFF);
    wr(0, 8'hFF); wr(0, 8'hFF);
  endtask

  task automatic t_hv_low;
    hv_ok = 1'b0;
    wr(0, 8'h40);
    wr(3, 8'h00);
    chk("R4 no busy without hv", {7'd0, busy}, 8'd0);
    cycles(P + 1);
    rd_chk("R4 byte 3 unchanged", 3, mexp[3]);
    wr(0, 8'h90);
    rd_chk("R4 id command ignored", 0, mexp[0]);
    hv_ok = 1'b1;
    wr(0, 8'h40);
    wr(3, 8'h00);
    cycles(P);
    mexp[3] = 8'h00;
    wr(0, 8'hFF); wr(0, 8'hFF);
    hv_ok = 1'b0;
    wr(0, 8'h20);
    chk("R4 erase ignored busy", {7'd0, busy}, 8'd0);
    cycles(P + 1);
    rd_chk("R4 erase ignored data", 3, mexp[3]);
    hv_ok = 1'b1;
  endtask

  task automatic t_hv_drop;
    wr(0, 8'h40);
    wr(4, 8'h00);
    cycles(3);
    hv_ok = 1'b0;
    cycles(1);
    chk("R11 abort clears busy", {7'd0, busy}, 8'd0);
    hv_ok = 1'b1;
    cycles(P);
    rd_chk("R11 byte 4 unchanged", 4, mexp[4]);
    wr(4, 8'h00);
    cycles(2);
    rd_chk("R11 back in array read", 4, mexp[4]);
  endtask

  task automatic t_reset_seq;
    wr(0, 8'h90);
    wr(0, 8'hFF);
    rd_chk("R10 single reset reads array", 3, mexp[3]);
    wr(0, 8'h90);
    rd_chk("R10 command after single reset", 0, 8'h5A);
    wr(0, 8'hFF); wr(0, 8'hFF);
    rd_chk("R10 double reset to array", 0, mexp[0]);
    rd_chk("R2 array read 3", 3, mexp[3]);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ident();
    t_program();
    t_early_verify();
    t_erase();
    t_hv_low();
    t_hv_drop();
    t_reset_seq();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule